// File: doc/BRIEF.md
# Module Idle Handshake Controller

This block is the low-power agent of a peripheral. A system power controller raises an idle request. The block answers with an idle acknowledge according to a policy chosen in its configuration register. The register offers three policies, and a fourth code is reserved:

- **force:** acknowledge at once.
- **never:** do not acknowledge.
- **interrupt-aware:** acknowledge only once no interrupt flag is pending.

When the request is withdrawn, the acknowledge falls and the block is active again.

Separately, an auto-idle bit in the same register lets the block close its internal clock gate whenever the configuration port is quiet. Any read or write strobe on that port reopens the gate combinationally, so the access that woke it is served in its own cycle.

Top module: `idlehs_ctrl`

## Requirements
- R1: The configuration register holds the auto-idle enable in bit 0 and the idle policy field in bits [4:3]. Codes are 00 force, 01 never, 10 interrupt-aware and 11 reserved. `cfg_rdata` returns those three bits in place and zero in every other bit. A write takes effect at the clock edge that samples `cfg_wr`.
- R2: After synchronous reset the register reads all zero (policy 00, auto-idle off), `idle_ack` is low and `clk_en` is high.
- R3: With policy 01, `idle_ack` never rises, however long `idle_req` is held.
- R4: With the reserved code 11, `idle_ack` never rises, the same as with policy 01.
- R5: With policy 00, `idle_ack` is high one cycle after `idle_req` is first sampled high, whatever `irq_pending` holds.
- R6: With policy 10, `idle_ack` stays low while any bit of `irq_pending` is set. It rises one cycle after the edge that samples `irq_pending` all zero together with `idle_req` high.
- R7: With policy 10, a flag that becomes pending again while the block is waiting keeps `idle_ack` low.
- R8: `idle_ack` falls one cycle after `idle_req` is sampled low. A later request is then judged afresh, and a request dropped while waiting leaves `idle_ack` low.
- R9: When auto-idle is set and neither `cfg_rd` nor `cfg_wr` is high, `clk_en` is low. When auto-idle is clear, `clk_en` is high.
- R10: `clk_en` is high in the same cycle as any `cfg_rd` or `cfg_wr` strobe, with no register in that path.
- R11: A policy write in the same cycle as the first sampled `idle_req` does not affect that request. The policy held before the write decides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Configuration read data |
| idle_req | input | 1 | Idle request from the power controller |
| irq_pending | input | NUM_IRQ | Pending interrupt flags, one per source |
| idle_ack | output | 1 | Idle acknowledge to the power controller |
| clk_en | output | 1 | Enable for the internal clock gate |

## Verification
A configuration write and the first sampled edge of an idle request can land in the same cycle. That collision decides which policy the request is answered under. The bench provokes it by writing the never policy over the force policy in exactly the cycle the request rises. It expects the acknowledge one cycle later, which is the old policy's answer, and then shows that the next request is refused under the new policy. Separately, a strobe during auto-idle is checked in its own cycle, before the next edge, to confirm the gate opens at once.

// File: rtl/idlehs_pkg.sv
package idlehs_pkg;

    localparam int AUTO_BIT   = 0;
    localparam int POL_LSB    = 3;
    localparam int POL_WIDTH  = 2;
    localparam int CFG_MIN_W  = POL_LSB + POL_WIDTH;

    typedef enum logic [1:0] {
        FLD_FORCE = 2'b00,
        FLD_NEVER = 2'b01,
        FLD_SMART = 2'b10,
        FLD_RSVD  = 2'b11
    } pol_field_e;

    typedef enum logic [1:0] {
        POL_FORCE,
        POL_NEVER,
        POL_SMART
    } ack_policy_e;

    typedef enum logic [1:0] {
        ST_ACTIVE,
        ST_WAIT,
        ST_IDLE
    } hs_state_e;

    typedef struct packed {
        pol_field_e pol;
        logic       auto_en;
    } cfg_s;

    function automatic ack_policy_e policy_of(pol_field_e f);
        case (f)
            FLD_FORCE: return POL_FORCE;
            FLD_SMART: return POL_SMART;
            default:   return POL_NEVER;
        endcase
    endfunction

endpackage

// File: rtl/idlehs_cfg_reg.sv
module idlehs_cfg_reg
    import idlehs_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_s             cfg_q,
    output logic [CFG_W-1:0] rdata
);

    cfg_s cfg_d;
    logic spare_unused;

    assign spare_unused = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.auto_en = wdata[AUTO_BIT];
            cfg_d.pol     = pol_field_e'(wdata[POL_LSB +: POL_WIDTH]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{pol: FLD_FORCE, auto_en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata                          = '0;
        rdata[AUTO_BIT]                = cfg_q.auto_en;
        rdata[POL_LSB +: POL_WIDTH]    = cfg_q.pol;
    end

    // R1: a write lands at the next edge.
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata[POL_LSB +: POL_WIDTH] == $past(wdata[POL_LSB +: POL_WIDTH]))
                  && (rdata[AUTO_BIT] == $past(wdata[AUTO_BIT])));

endmodule

// File: rtl/idlehs_autogate.sv
module idlehs_autogate (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic port_wr,
    input  logic port_rd,
    output logic clk_en
);

    logic port_busy;

    assign port_busy = port_wr | port_rd;
    assign clk_en    = !auto_en || port_busy;

    assert_gate_open_on_access_R10: assert property (@(posedge clk) disable iff (rst)
        (port_wr || port_rd) |-> clk_en);

    assert_gate_open_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !auto_en |-> clk_en);

endmodule

// File: rtl/idlehs_ack_fsm.sv
module idlehs_ack_fsm
    import idlehs_pkg::*;
#(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  ack_policy_e        policy,
    input  logic               idle_req,
    input  logic [NUM_IRQ-1:0] irq_pending,
    output logic               idle_ack
);

    hs_state_e state_q, state_d;
    logic      irq_any;

    assign irq_any = |irq_pending;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_ACTIVE: begin
                if (idle_req) begin
                    case (policy)
                        POL_FORCE: state_d = ST_IDLE;
                        POL_SMART: state_d = irq_any ? ST_WAIT : ST_IDLE;
                        default:   state_d = ST_ACTIVE;
                    endcase
                end
            end
            ST_WAIT: begin
                if (!idle_req)     state_d = ST_ACTIVE;
                else if (!irq_any) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!idle_req)     state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACTIVE;
        else     state_q <= state_d;
    end

    assign idle_ack = (state_q == ST_IDLE);

    assert_force_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && idle_req && policy == POL_FORCE) |=> idle_ack);

    assert_smart_holdoff_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && policy == POL_SMART && irq_any) |=> !idle_ack);

    assert_wait_keeps_waiting_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && irq_any) |=> !idle_ack);

    assert_ack_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (idle_ack && !idle_req) |=> !idle_ack);

endmodule

// File: rtl/idlehs_ctrl.sv
module idlehs_ctrl
    import idlehs_pkg::*;
#(
    parameter int CFG_W   = 8,
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               idle_req,
    input  logic [NUM_IRQ-1:0] irq_pending,
    output logic               idle_ack,
    output logic               clk_en
);

    cfg_s        cfg_q;
    ack_policy_e policy;

    generate
        if (CFG_W < CFG_MIN_W) begin : g_bad_width
            initial $error("idlehs_ctrl: CFG_W too small for the policy field");
        end
    endgenerate

    idlehs_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .rdata (cfg_rdata)
    );

    assign policy = policy_of(cfg_q.pol);

    idlehs_ack_fsm #(.NUM_IRQ(NUM_IRQ)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .policy      (policy),
        .idle_req    (idle_req),
        .irq_pending (irq_pending),
        .idle_ack    (idle_ack)
    );

    idlehs_autogate u_gate (
        .clk     (clk),
        .rst     (rst),
        .auto_en (cfg_q.auto_en),
        .port_wr (cfg_wr),
        .port_rd (cfg_rd),
        .clk_en  (clk_en)
    );

    assert_never_policy_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[POL_LSB +: POL_WIDTH] == 2'b01 && !idle_ack) |=> !idle_ack);

    assert_reserved_code_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[POL_LSB +: POL_WIDTH] == 2'b11 && !idle_ack) |=> !idle_ack);

endmodule

// File: tb/idlehs_ctrl_test.sv
`timescale 1ns/1ps
module idlehs_ctrl_test;

    localparam int CFG_W   = 8;
    localparam int NUM_IRQ = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_wr = 1'b0;
    logic               cfg_rd = 1'b0;
    logic [CFG_W-1:0]   cfg_wdata = '0;
    logic [CFG_W-1:0]   cfg_rdata;
    logic               idle_req = 1'b0;
    logic [NUM_IRQ-1:0] irq_pending = '0;
    logic               idle_ack;
    logic               clk_en;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    idlehs_ctrl #(.CFG_W(CFG_W), .NUM_IRQ(NUM_IRQ)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .idle_req(idle_req),
        .irq_pending(irq_pending), .idle_ack(idle_ack), .clk_en(clk_en)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] cfg_word(logic [1:0] pol, logic auto_en);
        logic [CFG_W-1:0] w = '0;
        w[4:3] = pol;
        w[0]   = auto_en;
        return w;
    endfunction

    task automatic wr_cfg(logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        #1 chk("R10 clk_en during write", 32'(clk_en), 1);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R2 rdata after reset", 32'(cfg_rdata), 0);
        chk("R2 idle_ack after reset", 32'(idle_ack), 0);
        chk("R2 clk_en after reset", 32'(clk_en), 1);
    endtask

    task automatic t_readback();
        wr_cfg(cfg_word(2'b10, 1'b1));
        #1 chk("R1 readback smart+auto", 32'(cfg_rdata), 32'h11);
        wr_cfg(8'hFF);
        #1 chk("R1 readback all ones", 32'(cfg_rdata), 32'h19);
        wr_cfg(cfg_word(2'b00, 1'b0));
        #1 chk("R1 readback cleared", 32'(cfg_rdata), 0);
    endtask

    task automatic t_force();
        irq_pending = 4'hF;
        wr_cfg(cfg_word(2'b00, 1'b0));
        @(negedge clk); idle_req = 1'b1;
        #1 chk("R5 no ack before edge", 32'(idle_ack), 0);
        @(negedge clk);
        #1 chk("R5 force ack despite pending", 32'(idle_ack), 1);
        idle_req = 1'b0;
        @(negedge clk);
        #1 chk("R8 ack drops after release", 32'(idle_ack), 0);
        irq_pending = '0;
    endtask

    task automatic t_never(logic [1:0] code, string tag);
        int bad = 0;
        wr_cfg(cfg_word(code, 1'b0));
        @(negedge clk); idle_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1 if (idle_ack !== 1'b0) bad++;
        end
        chk(tag, 32'(bad), 0);
        idle_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_smart();
        int bad = 0;
        wr_cfg(cfg_word(2'b10, 1'b0));
        @(negedge clk); irq_pending = 4'b0101; idle_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1 if (idle_ack !== 1'b0) bad++;
        end
        chk("R6 held off while pending", 32'(bad), 0);
        irq_pending = 4'b0100;
        @(negedge clk); #1 chk("R6 one flag still pending", 32'(idle_ack), 0);
        irq_pending = 4'b0110;
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1 if (idle_ack !== 1'b0) bad++;
        end
        chk("R7 new flag keeps waiting", 32'(bad), 0);
        irq_pending = '0;
        #1 chk("R6 not yet before edge", 32'(idle_ack), 0);
        @(negedge clk); #1 chk("R6 ack after flags clear", 32'(idle_ack), 1);
        idle_req = 1'b0;
        @(negedge clk); #1 chk("R8 smart ack drops", 32'(idle_ack), 0);
        idle_req = 1'b1;
        @(negedge clk); #1 chk("R6 ack at once when nothing pending", 32'(idle_ack), 1);
        idle_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_abort();
        int bad = 0;
        @(negedge clk); irq_pending = 4'b1000; idle_req = 1'b1;
        repeat (3) @(negedge clk);
        idle_req = 1'b0;
        @(negedge clk); irq_pending = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1 if (idle_ack !== 1'b0) bad++;
        end
        chk("R8 dropped request while waiting", 32'(bad), 0);
        idle_req = 1'b1;
        @(negedge clk); #1 chk("R8 fresh request served", 32'(idle_ack), 1);
        idle_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_autogate();
        wr_cfg(cfg_word(2'b00, 1'b1));
        #1 chk("R9 gate closed when quiet", 32'(clk_en), 0);
        @(negedge clk); cfg_rd = 1'b1;
        #1 chk("R10 gate opens on read same cycle", 32'(clk_en), 1);
        @(negedge clk); cfg_rd = 1'b0;
        #1 chk("R9 gate closes again", 32'(clk_en), 0);
        wr_cfg(cfg_word(2'b00, 1'b0));
        #1 chk("R9 gate open when auto off", 32'(clk_en), 1);
    endtask

    task automatic t_collision();
        int bad = 0;
        wr_cfg(cfg_word(2'b00, 1'b0));
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = cfg_word(2'b01, 1'b0); idle_req = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        #1 chk("R11 old policy governs request", 32'(idle_ack), 1);
        idle_req = 1'b0;
        @(negedge clk); #1 chk("R11 ack drops", 32'(idle_ack), 0);
        idle_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1 if (idle_ack !== 1'b0) bad++;
        end
        chk("R11 new policy refuses next request", 32'(bad), 0);
        idle_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_force();
        t_never(2'b01, "R3 never policy holds ack low");
        t_never(2'b11, "R4 reserved code holds ack low");
        t_smart();
        t_abort();
        t_autogate();
        t_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule